// File: doc/BRIEF.md
# SPI Register-File Slave

This block is an SPI slave that owns a small bank of byte-wide registers and lets an external master read or write one register per transaction. The SPI pins are asynchronous to the block. Chip select, the serial clock and the serial data input pass through a two-flop synchronizer and are then handled in the system clock domain, which must run at least eight times faster than the serial clock. The bus uses mode 0: the clock idles low, and data is captured on the rising edge and launched so that it is stable at the falling edge. Bytes travel most significant bit first.

A transaction opens when chip select goes low. The first byte is a header: its top bit picks the direction (0 = write, 1 = read) and the lower seven bits pick a register index. A write carries a second byte, 16 serial clocks in all, and the byte is stored once its eighth bit arrives. A read returns the register in 15 serial clocks. The first returned bit goes out on the same rising edge that completes the header, so the master can sample it on the following falling edge.

The state machine has five states. IDLE waits for chip select low and moves to HDR. HDR shifts in eight bits, then moves to WR_BYTE or RD_BYTE according to the header's top bit. WR_BYTE shifts in eight bits, stores the byte and moves to HOLD. RD_BYTE shifts out the seven remaining bits and moves to HOLD. HOLD waits and keeps the serial output steady. A high chip select sends every state back to IDLE. A parallel port shows the contents of every register at all times.

Top module: `spi_regfile_slave`

## Requirements
- R1: After the asynchronous active-low reset, every register reads 0x00 on the debug port and the serial output is 0.
- R2: While chip select is high the serial output is 0, and serial clock or data activity changes no register.
- R3: A header whose bit 7 is 0, followed by a data byte (16 serial clocks, MSB first), stores that byte in the register given by header bits 6:0.
- R4: A header whose bit 7 is 1 returns the addressed register MSB first in 15 serial clocks. Bit 7 of the register is valid at the falling edge of the eighth header clock, and bit 0 is valid at the falling edge of the fifteenth clock.
- R5: Indexes 16 to 127 have no register behind them. A read of such an index returns 0x00, and a write to one changes nothing.
- R6: If chip select rises before all eight bits of a write byte have arrived, the write is dropped and every register keeps its value.
- R7: A new transaction that starts after chip select has been high for only 4 system clock cycles is served correctly.
- R8: Bits [8*i+7:8*i] of the debug port always equal register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master, mode 0 |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master; 0 while deselected |
| dbg_regs | output | NUM_REGS*DATA_W | All register contents, register i in byte lane i |

## Verification
Two events fall on the same detected serial clock edge: the header byte completes, and the first read bit is launched. The register lookup uses the header as it stands on that edge, including the bit just received. Reads are issued to many different indexes, and the master samples the output on the eighth falling edge. Each returned byte is compared in full against a register model kept by the bench. Writes and reads are interleaved with minimum 4-cycle chip-select gaps, so that the step back to idle overlaps the next header.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WR_BYTE,
        ST_RD_BYTE,
        ST_HOLD
    } spi_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 8,
    parameter int IDX_W    = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [IDX_W-1:0]           waddr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [IDX_W-1:0]           raddr,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [NUM_REGS-1:0][DATA_W-1:0] mem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (we && (32'(waddr) < NUM_REGS)) begin
            mem[waddr[SEL_W-1:0]] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (32'(raddr) < NUM_REGS) rdata = mem[raddr[SEL_W-1:0]];
    end

    assign regs_flat = mem;

    // R6
    r6_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem));

    // R5
    r5_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (32'(waddr) >= NUM_REGS)) |=> $stable(mem));
endmodule

// File: rtl/spi_slave_fsm.sv
module spi_slave_fsm
    import spi_rf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rdata,
    output logic [IDX_W-1:0]  raddr,
    output logic              we,
    output logic [IDX_W-1:0]  waddr,
    output logic [DATA_W-1:0] wdata,
    output logic              miso_q
);
    localparam int CNT_W = $clog2(DATA_W);

    spi_state_e        st, st_nx;
    logic              sclk_d;
    logic              rise;
    logic [CNT_W-1:0]  cnt;
    logic              last;
    logic [DATA_W-1:0] shin;
    logic [DATA_W-1:0] byte_now;
    logic [DATA_W-1:0] sout;
    logic [IDX_W-1:0]  idx_q;

    assign rise     = sclk_s & ~sclk_d;
    assign last     = (cnt == CNT_W'(DATA_W-1));
    assign byte_now = {shin[DATA_W-2:0], mosi_s};
    assign raddr    = byte_now[IDX_W-1:0];
    assign waddr    = idx_q;
    assign wdata    = byte_now;
    assign we       = (st == ST_WR_BYTE) && rise && last && !cs_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:    if (!cs_s) st_nx = ST_HDR;
            ST_HDR:     if (rise && last)
                            st_nx = byte_now[DATA_W-1] ? ST_RD_BYTE : ST_WR_BYTE;
            ST_WR_BYTE: if (rise && last) st_nx = ST_HOLD;
            ST_RD_BYTE: if (rise && cnt == CNT_W'(DATA_W-2)) st_nx = ST_HOLD;
            ST_HOLD:    st_nx = ST_HOLD;
            default:    st_nx = ST_IDLE;
        endcase
        if (cs_s) st_nx = ST_IDLE;
    end

    // output and datapath process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cnt    <= '0;
            shin   <= '0;
            sout   <= '0;
            idx_q  <= '0;
            miso_q <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            if (cs_s) begin
                cnt    <= '0;
                shin   <= '0;
                sout   <= '0;
                miso_q <= 1'b0;
            end else if (rise) begin
                unique case (st)
                    ST_HDR: begin
                        shin <= byte_now;
                        cnt  <= cnt + 1'b1;
                        if (last) begin
                            idx_q <= byte_now[IDX_W-1:0];
                            if (byte_now[DATA_W-1]) begin
                                miso_q <= rdata[DATA_W-1];
                                sout   <= rdata << 1;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        shin <= byte_now;
                        cnt  <= cnt + 1'b1;
                    end
                    ST_RD_BYTE: begin
                        miso_q <= sout[DATA_W-1];
                        sout   <= sout << 1;
                        cnt    <= cnt + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    r2_cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (st == ST_IDLE));

    // R4
    r4_miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RD_BYTE || st == ST_HOLD) && !rise && !cs_s) |=> $stable(miso_q));

    // R3
    r3_write_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (st == ST_HOLD || st == ST_IDLE));
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave #(
    parameter int NUM_REGS    = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk,
    input  logic                       cs_n,
    input  logic                       mosi,
    output logic                       miso,
    output logic [NUM_REGS*DATA_W-1:0] dbg_regs
);
    localparam int IDX_W = DATA_W - 1;

    logic [2:0]        pins_s;
    logic              cs_s, sclk_s, mosi_s;
    logic [IDX_W-1:0]  raddr, waddr;
    logic [DATA_W-1:0] rdata, wdata;
    logic              we, miso_q;

    spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sclk, mosi}),
        .dout (pins_s)
    );
    assign {cs_s, sclk_s, mosi_s} = pins_s;

    spi_slave_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_s  (cs_s),
        .sclk_s(sclk_s),
        .mosi_s(mosi_s),
        .rdata (rdata),
        .raddr (raddr),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .miso_q(miso_q)
    );

    spi_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (we),
        .waddr    (waddr),
        .wdata    (wdata),
        .raddr    (raddr),
        .rdata    (rdata),
        .regs_flat(dbg_regs)
    );

    assign miso = ~cs_n & miso_q;
endmodule

// File: tb/sim_spi_regfile_slave.sv
`timescale 1ns/1ps
module sim_spi_regfile_slave;
    localparam int  NREG = 16;
    localparam time CLK  = 5;
    localparam time HALF = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;
    logic [NREG*8-1:0] dbg_regs;

    int compared = 0;
    int mismatched = 0;
    logic [7:0] model [NREG];

    always #(CLK/2.0) clk = ~clk;

    spi_regfile_slave u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
        .mosi(mosi), .miso(miso), .dbg_regs(dbg_regs)
    );

    // {read, index[6:0], data[7:0]}
    localparam logic [15:0] VEC [13] = '{
        16'h00A5, 16'h0F3C, 16'h0781, 16'h20FF, 16'h8000,
        16'h8F00, 16'h8700, 16'hA000, 16'h077E, 16'h8700,
        16'h8500, 16'h7F55, 16'hFF00
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    task automatic spi_xfer(input logic rd, input logic [6:0] idx, input logic [7:0] wd,
                            input int ndata, output logic [7:0] rv);
        logic [7:0] hdr;
        hdr = {rd, idx};
        rv = '0;
        cs_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            mosi = hdr[7-i];
            #HALF sclk = 1'b1;
            #HALF if (rd && i == 7) rv[7] = miso;
            sclk = 1'b0;
        end
        if (rd) begin
            for (int j = 1; j < 8; j++) begin
                mosi = 1'b0;
                #HALF sclk = 1'b1;
                #HALF rv[7-j] = miso;
                sclk = 1'b0;
            end
        end else begin
            for (int j = 0; j < ndata; j++) begin
                mosi = wd[7-j];
                #HALF sclk = 1'b1;
                #HALF sclk = 1'b0;
            end
        end
        #HALF cs_n = 1'b1;
        mosi = 1'b0;
        #(4*CLK);
    endtask

    initial begin
        #(100000*CLK);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        #(4*CLK + CLK/2.0);
        // R1 reset state
        check("R1 regs in reset", 128'(dbg_regs), 128'(0));
        check("R1 miso in reset", 128'(miso), 128'(0));
        rst_n = 1'b1;
        #(4*CLK);
        check("R1 regs after reset", 128'(dbg_regs), 128'(0));

        // vector walk: R3 writes, R4 reads, R5 unmapped, R7 4-cycle gaps
        for (int v = 0; v < 13; v++) begin
            spi_xfer(VEC[v][15], VEC[v][14:8], VEC[v][7:0], 8, rv);
            if (VEC[v][15]) begin
                check($sformatf("R4/R5 read idx %0h", VEC[v][14:8]), 128'(rv),
                      128'((VEC[v][14:8] < NREG) ? model[VEC[v][11:8]] : 8'h00));
            end else begin
                if (VEC[v][14:8] < NREG) model[VEC[v][11:8]] = VEC[v][7:0];
                check($sformatf("R3/R5 regs after write idx %0h", VEC[v][14:8]),
                      128'(dbg_regs), 128'(model_flat()));
            end
        end
        // R8 debug port lanes
        for (int i = 0; i < NREG; i++)
            check($sformatf("R8 lane %0d", i), 128'(dbg_regs[i*8 +: 8]), 128'(model[i]));

        // R6 aborted write after 4 and 7 data bits
        spi_xfer(1'b0, 7'h00, 8'h11, 4, rv);
        check("R6 abort after 4 bits", 128'(dbg_regs), 128'(model_flat()));
        spi_xfer(1'b0, 7'h0F, 8'hEE, 7, rv);
        check("R6 abort after 7 bits", 128'(dbg_regs), 128'(model_flat()));
        spi_xfer(1'b1, 7'h0F, 8'h00, 8, rv);
        check("R6 read back after abort", 128'(rv), 128'(model[15]));

        // R2 bus activity with chip select high
        for (int k = 0; k < 16; k++) begin
            mosi = k[0];
            #HALF sclk = 1'b1;
            #HALF check("R2 miso while deselected", 128'(miso), 128'(0));
            sclk = 1'b0;
        end
        check("R2 regs untouched while deselected", 128'(dbg_regs), 128'(model_flat()));

        // R7 back-to-back write then read at minimum gap
        spi_xfer(1'b0, 7'h03, 8'hC9, 8, rv);
        model[3] = 8'hC9;
        spi_xfer(1'b1, 7'h03, 8'h00, 8, rv);
        check("R7 back-to-back read", 128'(rv), 128'(8'hC9));

        // R1 reset again clears
        rst_n = 1'b0;
        #(2*CLK);
        check("R1 regs after second reset", 128'(dbg_regs), 128'(0));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule